// File: doc/BRIEF.md
# Two-Rail Return-to-Zero Receive Channel

This block is one receive channel for a serial word stream carried on two logic-level rails in return-to-zero form. A pulse on rail A marks a one, a pulse on rail B marks a zero, and both rails low marks a null. The rails come either from the line or from a loopback source. Samples are taken at ten times the bit rate. A bit is accepted only after its start has been confirmed. Words of 25 or 32 bits are framed, with bit 1 arriving first.

A completed word can be filtered on its two source/destination bits. It is then copied into a single holding buffer, which a host reads as two 16-bit halves. While the buffer is unread it is never overwritten. A newer word waits in the shift register until the buffer is free, and a later arrival may replace it there. Data-ready clears on the read strobe that completes reading both halves. A parity status output reports whether the held word has an even number of ones.

Top module: `rz_rx_channel`

## Requirements
- R1: A sample is taken on every clock when rate_slow_i is 0, and once every SLOW_DIV clocks when it is 1. A sample with rail A high and B low is a one symbol, B high and A low is a zero symbol, and both low is a null symbol.
- R2: A bit is accepted only if its symbol is present at the start sample and at each of the two following samples. A pulse shorter than three samples drops the current word.
- R3: A word has 32 bits when wlen25_i is 0 and 25 bits when it is 1. Half 0 (sel_i=0) shows serial bits 1..16 on data_o[0..15]. Half 1 shows serial bits 17..32 on data_o[0..15], and bits beyond the word length read as 0.
- R4: A word is accepted only with at least SPB consecutive null samples before its first bit and after its last bit. A start sooner than that after the last bit drops the word, and the channel then waits for SPB nulls.
- R5: A run of SPB null samples before all bits have arrived drops the partial word.
- R6: A sample with both rails high drops the word in progress.
- R7: When sd_en_i is 1, a word is accepted only if serial bit 9 equals sd_x_i and serial bit 10 equals sd_y_i.
- R8: While data-ready is active the holding buffer keeps its word. The latest accepted word waits and is latched once data-ready clears. An accepted word arriving later replaces the waiting one.
- R9: drdy_no goes low when a word is latched. It goes high on the clock after the falling edge of oe_ni that completes reading both halves, and sel_i at that edge picks the half. A single-half read leaves it low.
- R10: par_even_o is 0 when the held word has an odd number of ones and 1 when the count is even.
- R11: With loop_en_i at 1 the loop rails replace the line rails, which are then ignored. With LOOP_INV=1 the loop rails are swapped, so the word received is the complement of the one sent.
- R12: After reset drdy_no is 1, the buffer is zero and par_even_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock, ten times the fast bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_slow_i | input | 1 | 1 selects the slow bit rate |
| wlen25_i | input | 1 | 1 selects 25-bit words, 0 selects 32-bit words |
| loop_en_i | input | 1 | 1 selects the loopback rails |
| line_a_i | input | 1 | Line rail A (one pulses) |
| line_b_i | input | 1 | Line rail B (zero pulses) |
| loop_a_i | input | 1 | Loopback rail A from the transmitter |
| loop_b_i | input | 1 | Loopback rail B from the transmitter |
| sd_en_i | input | 1 | Enables source/destination filtering |
| sd_x_i | input | 1 | Value expected on serial bit 9 |
| sd_y_i | input | 1 | Value expected on serial bit 10 |
| oe_ni | input | 1 | Read strobe, active low |
| sel_i | input | 1 | Half select: 0 for bits 1..16, 1 for bits 17..32 |
| data_o | output | 16 | Selected half of the holding buffer |
| drdy_no | output | 1 | Data ready, active low |
| par_even_o | output | 1 | 1 when the held word has an even number of ones |

## Verification
The bench builds the channel with LOOP_INV=1 and otherwise default parameters: SPB=10, SLOW_DIV=8 and WMAX=32. This lets the loopback test check that the sent word comes back inverted. It also makes each slow-rate bit eighty clocks long, so the slow path is covered in a few thousand cycles. With the default SPB, the pulse-width tests can probe the three-sample confirmation boundary. They also exercise the one-bit-time null windows before and after a word.

// File: rtl/rz_rx_pkg.sv
package rz_rx_pkg;
  typedef enum logic [1:0] {
    SYM_NULL = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_ZERO = 2'd2,
    SYM_BAD  = 2'd3
  } sym_t;

  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,  // need SPB nulls before a word may start
    ST_IDLE = 3'd1,
    ST_CONF = 3'd2,
    ST_HIGH = 3'd3,
    ST_GAP  = 3'd4
  } fr_st_t;
endpackage

// File: rtl/rz_rx_front.sv
module rz_rx_front
  import rz_rx_pkg::*;
#(
  parameter int SLOW_DIV = 8,
  parameter bit LOOP_INV = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rate_slow_i,
  input  logic loop_en_i,
  input  logic line_a_i,
  input  logic line_b_i,
  input  logic loop_a_i,
  input  logic loop_b_i,
  output logic tick_o,
  output sym_t sym_o
);
  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic lb_a, lb_b, raw_a, raw_b;
  logic [1:0] sync_a_q, sync_b_q;
  logic [DIV_W-1:0] div_q;

  generate
    if (LOOP_INV) begin : g_loop_inv
      assign lb_a = loop_b_i;
      assign lb_b = loop_a_i;
    end else begin : g_loop_dir
      assign lb_a = loop_a_i;
      assign lb_b = loop_b_i;
    end
  endgenerate

  assign raw_a = loop_en_i ? lb_a : line_a_i;
  assign raw_b = loop_en_i ? lb_b : line_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_a_q <= '0;
      sync_b_q <= '0;
      div_q    <= '0;
    end else begin
      sync_a_q <= {sync_a_q[0], raw_a};
      sync_b_q <= {sync_b_q[0], raw_b};
      div_q    <= (div_q == DIV_W'(SLOW_DIV - 1)) ? '0 : div_q + 1'b1;
    end
  end

  assign tick_o = rate_slow_i ? (div_q == '0) : 1'b1;

  always_comb begin
    unique case ({sync_a_q[1], sync_b_q[1]})
      2'b10:   sym_o = SYM_ONE;
      2'b01:   sym_o = SYM_ZERO;
      2'b11:   sym_o = SYM_BAD;
      default: sym_o = SYM_NULL;
    endcase
  end

  // R1
  slow_tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_slow_i && tick_o) |=> (!rate_slow_i || !tick_o));
endmodule

// File: rtl/rz_rx_framer.sv
module rz_rx_framer
  import rz_rx_pkg::*;
#(
  parameter int WMAX      = 32,
  parameter int SHORT_LEN = 25,
  parameter int SPB       = 10,
  parameter int CONF      = 2,
  parameter int SD_BIT    = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  sym_t            sym_i,
  input  logic            wlen25_i,
  input  logic            sd_en_i,
  input  logic            sd_x_i,
  input  logic            sd_y_i,
  output logic [WMAX-1:0] word_o,
  output logic            word_ok_o,
  output logic            start_o
);
  localparam int CNT_W = $clog2(SPB + 1);
  localparam int BC_W  = $clog2(WMAX + 1);
  localparam int IDX_W = $clog2(WMAX);
  localparam int SD_IX = SD_BIT - 1;

  fr_st_t          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BC_W-1:0]  bcnt_q, bcnt_d, len_q, len_d;
  sym_t             bsym_q, bsym_d;
  logic [WMAX-1:0]  shift_q, shift_d;
  logic             done, sd_ok;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bcnt_d  = bcnt_q;
    len_d   = len_q;
    bsym_d  = bsym_q;
    shift_d = shift_q;
    done    = 1'b0;
    start_o = 1'b0;
    if (tick_i) begin
      unique case (state_q)
        ST_WAIT: begin
          if (sym_i != SYM_NULL) cnt_d = '0;
          else if (cnt_q == CNT_W'(SPB - 1)) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_IDLE: begin
          if (sym_i == SYM_BAD) begin
            state_d = ST_WAIT;
            cnt_d   = '0;
          end else if (sym_i != SYM_NULL) begin
            start_o = 1'b1;
            shift_d = '0;
            bcnt_d  = '0;
            len_d   = wlen25_i ? BC_W'(SHORT_LEN) : BC_W'(WMAX);
            bsym_d  = sym_i;
            cnt_d   = '0;
            state_d = ST_CONF;
          end
        end
        ST_CONF: begin
          if (sym_i != bsym_q) begin
            state_d = ST_WAIT;
            cnt_d   = '0;
          end else if (cnt_q == CNT_W'(CONF - 1)) begin
            shift_d[bcnt_q[IDX_W-1:0]] = (bsym_q == SYM_ONE);
            bcnt_d  = bcnt_q + 1'b1;
            state_d = ST_HIGH;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_HIGH: begin
          if (sym_i == SYM_NULL) begin
            state_d = ST_GAP;
            cnt_d   = CNT_W'(1);
          end else if (sym_i != bsym_q) begin
            state_d = ST_WAIT;
            cnt_d   = '0;
          end
        end
        ST_GAP: begin
          if (sym_i == SYM_NULL) begin
            if (cnt_q == CNT_W'(SPB - 1)) begin
              state_d = ST_IDLE;
              cnt_d   = '0;
              done    = (bcnt_q == len_q);  // short word: dropped
            end else cnt_d = cnt_q + 1'b1;
          end else if (sym_i == SYM_BAD || bcnt_q == len_q) begin
            state_d = ST_WAIT;
            cnt_d   = '0;
          end else begin
            bsym_d  = sym_i;
            cnt_d   = '0;
            state_d = ST_CONF;
          end
        end
        default: begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      bcnt_q  <= '0;
      len_q   <= BC_W'(WMAX);
      bsym_q  <= SYM_NULL;
      shift_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bcnt_q  <= bcnt_d;
      len_q   <= len_d;
      bsym_q  <= bsym_d;
      shift_q <= shift_d;
    end
  end

  assign sd_ok     = !sd_en_i || (shift_q[SD_IX] == sd_x_i && shift_q[SD_IX+1] == sd_y_i);
  assign word_ok_o = done && sd_ok;
  assign word_o    = shift_q;

  // R6
  bad_sym_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && sym_i == SYM_BAD) |=> (state_q == ST_WAIT));
  // R3
  word_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ok_o |-> ((len_q == BC_W'(SHORT_LEN) || len_q == BC_W'(WMAX)) && bcnt_q == len_q));
  // R2
  conf_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcnt_q != $past(bcnt_q) && bcnt_q != '0) |-> ($past(state_q) == ST_CONF));
endmodule

// File: rtl/rz_rx_holdbuf.sv
module rz_rx_holdbuf #(
  parameter int WMAX = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WMAX-1:0]   word_i,
  input  logic              word_ok_i,
  input  logic              start_i,
  input  logic              oe_ni,
  input  logic              sel_i,
  output logic [WMAX/2-1:0] data_o,
  output logic              drdy_no,
  output logic              par_even_o
);
  localparam int HALF = WMAX / 2;

  logic [WMAX-1:0] buf_q;
  logic full_q, pend_q, rd0_q, rd1_q, oe_q;
  logic rd_edge, rd_done, load;

  assign rd_edge = oe_q && !oe_ni;
  assign rd_done = full_q && rd_edge && (sel_i ? rd0_q : rd1_q);
  // pending word still sits in the framer shift register
  assign load    = !full_q && (word_ok_i || pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      pend_q <= 1'b0;
      rd0_q  <= 1'b0;
      rd1_q  <= 1'b0;
      oe_q   <= 1'b1;
    end else begin
      oe_q <= oe_ni;
      if (rd_done) begin
        full_q <= 1'b0;
        rd0_q  <= 1'b0;
        rd1_q  <= 1'b0;
      end else if (load) begin
        full_q <= 1'b1;
        buf_q  <= word_i;
        rd0_q  <= 1'b0;
        rd1_q  <= 1'b0;
      end else if (rd_edge && full_q) begin
        if (sel_i) rd1_q <= 1'b1;
        else       rd0_q <= 1'b1;
      end
      if (word_ok_i && full_q)  pend_q <= 1'b1;
      else if (start_i || load) pend_q <= 1'b0;
    end
  end

  assign data_o     = sel_i ? buf_q[WMAX-1:HALF] : buf_q[HALF-1:0];
  assign drdy_no    = !full_q;
  assign par_even_o = ~^buf_q;

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !rd_done) |=> $stable(buf_q));
  // R9
  drdy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drdy_no) |-> $past(rd_edge));
endmodule

// File: rtl/rz_rx_channel.sv
module rz_rx_channel
  import rz_rx_pkg::*;
#(
  parameter int WMAX      = 32,
  parameter int SHORT_LEN = 25,
  parameter int SPB       = 10,
  parameter int SLOW_DIV  = 8,
  parameter bit LOOP_INV  = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rate_slow_i,
  input  logic        wlen25_i,
  input  logic        loop_en_i,
  input  logic        line_a_i,
  input  logic        line_b_i,
  input  logic        loop_a_i,
  input  logic        loop_b_i,
  input  logic        sd_en_i,
  input  logic        sd_x_i,
  input  logic        sd_y_i,
  input  logic        oe_ni,
  input  logic        sel_i,
  output logic [15:0] data_o,
  output logic        drdy_no,
  output logic        par_even_o
);
  logic            tick;
  sym_t            sym;
  logic [WMAX-1:0] word;
  logic            word_ok, start;

  rz_rx_front #(.SLOW_DIV(SLOW_DIV), .LOOP_INV(LOOP_INV)) u_front (
    .clk_i, .rst_ni, .rate_slow_i, .loop_en_i,
    .line_a_i, .line_b_i, .loop_a_i, .loop_b_i,
    .tick_o(tick), .sym_o(sym)
  );

  rz_rx_framer #(.WMAX(WMAX), .SHORT_LEN(SHORT_LEN), .SPB(SPB)) u_framer (
    .clk_i, .rst_ni, .tick_i(tick), .sym_i(sym), .wlen25_i,
    .sd_en_i, .sd_x_i, .sd_y_i,
    .word_o(word), .word_ok_o(word_ok), .start_o(start)
  );

  rz_rx_holdbuf #(.WMAX(WMAX)) u_hold (
    .clk_i, .rst_ni, .word_i(word), .word_ok_i(word_ok), .start_i(start),
    .oe_ni, .sel_i, .data_o, .drdy_no, .par_even_o
  );
endmodule

// File: tb/sim_rz_rx_channel.sv
module sim_rz_rx_channel;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rate_slow = 1'b0, wlen25 = 1'b0, loop_en = 1'b0;
  logic line_a = 1'b0, line_b = 1'b0, loop_a = 1'b0, loop_b = 1'b0;
  logic sd_en = 1'b0, sd_x = 1'b0, sd_y = 1'b0;
  logic oe_n = 1'b1, sel = 1'b0;
  logic [15:0] data;
  logic drdy_n, par_even;

  int n_chk = 0, n_bad = 0;
  int spc = 1;
  bit use_loop = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rz_rx_channel #(.LOOP_INV(1'b1)) u0 (
    .clk_i(clk), .rst_ni, .rate_slow_i(rate_slow), .wlen25_i(wlen25),
    .loop_en_i(loop_en), .line_a_i(line_a), .line_b_i(line_b),
    .loop_a_i(loop_a), .loop_b_i(loop_b), .sd_en_i(sd_en), .sd_x_i(sd_x),
    .sd_y_i(sd_y), .oe_ni(oe_n), .sel_i(sel), .data_o(data),
    .drdy_no(drdy_n), .par_even_o(par_even)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rails(input logic a, input logic b, input int n);
    if (use_loop) begin loop_a = a; loop_b = b; end
    else begin line_a = a; line_b = b; end
    repeat (n) @(negedge clk);
  endtask

  // mode per bit: 0 normal, 1 short pulse, 2 both rails high
  task automatic send(input logic [31:0] w, input int len, input int trail,
                      input int odd_bit, input int mode);
    for (int i = 0; i < len; i++) begin
      if (i == odd_bit && mode == 1) begin
        rails(w[i], ~w[i], 2 * spc);
        rails(1'b0, 1'b0, 8 * spc);
      end else if (i == odd_bit && mode == 2) begin
        rails(1'b1, 1'b1, 5 * spc);
        rails(1'b0, 1'b0, 5 * spc);
      end else begin
        rails(w[i], ~w[i], 5 * spc);
        rails(1'b0, 1'b0, 5 * spc);
      end
    end
    rails(1'b0, 1'b0, trail * spc);
  endtask

  function automatic logic [31:0] mask(input logic [31:0] w, input int len);
    return (len == 32) ? w : (w & ((32'd1 << len) - 1));
  endfunction

  task automatic read_word(input string req, input logic [31:0] exp);
    @(negedge clk); sel = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    check({req, " half0"}, {16'h0, data}, {16'h0, exp[15:0]});
    check("R9 drdy low after one half", {31'h0, drdy_n}, 32'h0);
    oe_n = 1'b1;
    @(negedge clk); sel = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    check({req, " half1"}, {16'h0, data}, {16'h0, exp[31:16]});
    check("R9 drdy high after both halves", {31'h0, drdy_n}, 32'h1);
    oe_n = 1'b1; sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R12 drdy after reset", {31'h0, drdy_n}, 32'h1);
    check("R12 data after reset", {16'h0, data}, 32'h0);
    check("R12 parity after reset", {31'h0, par_even}, 32'h1);
  endtask

  task automatic t_basic;
    logic [31:0] w;
    w = 32'hA5C3_1E47;
    send(w, 32, 15, -1, 0);
    check("R9 drdy low on latch", {31'h0, drdy_n}, 32'h0);
    check("R10 even count", {31'h0, par_even}, {31'h0, ~^w});
    read_word("R3 32-bit word", w);
    w = 32'h0000_0001;
    send(w, 32, 15, -1, 0);
    check("R10 odd count", {31'h0, par_even}, 32'h0);
    read_word("R3 single one", w);
  endtask

  task automatic t_len25;
    logic [31:0] w;
    w = 32'hFFFF_FFFF;
    wlen25 = 1'b1;
    send(w, 25, 15, -1, 0);
    check("R10 25 ones odd", {31'h0, par_even}, 32'h0);
    read_word("R3 25-bit word", mask(w, 25));
    wlen25 = 1'b0;
  endtask

  task automatic t_sd;
    logic [31:0] w;
    sd_en = 1'b1; sd_x = 1'b1; sd_y = 1'b0;
    w = 32'h1234_0200;  // bit9=0 bit10=1: mismatch
    send(w, 32, 15, -1, 0);
    check("R7 mismatch ignored", {31'h0, drdy_n}, 32'h1);
    w = 32'h1234_0100;  // bit9=1 bit10=0: match
    send(w, 32, 15, -1, 0);
    check("R7 match accepted", {31'h0, drdy_n}, 32'h0);
    read_word("R7 matched word", w);
    sd_en = 1'b0;
  endtask

  task automatic t_break;
    send(32'h5555_5555, 20, 25, -1, 0);
    check("R5 partial word dropped", {31'h0, drdy_n}, 32'h1);
  endtask

  task automatic t_no_trail;
    send(32'h0F0F_0F0F, 32, 0, -1, 0);
    send(32'hF0F0_F0F0, 32, 15, -1, 0);
    check("R4 unframed words dropped", {31'h0, drdy_n}, 32'h1);
    send(32'h0000_ABCD, 32, 15, -1, 0);
    read_word("R4 recovery word", 32'h0000_ABCD);
  endtask

  task automatic t_bad;
    send(32'h7777_7777, 32, 15, 5, 2);
    check("R6 both rails high dropped", {31'h0, drdy_n}, 32'h1);
  endtask

  task automatic t_glitch;
    send(32'h3333_3333, 32, 15, 3, 1);
    check("R2 unconfirmed pulse dropped", {31'h0, drdy_n}, 32'h1);
  endtask

  task automatic t_hold;
    send(32'hAAAA_0001, 32, 15, -1, 0);
    send(32'hBBBB_0002, 32, 15, -1, 0);
    send(32'hCCCC_0003, 32, 15, -1, 0);
    check("R8 buffer held while ready", {16'h0, data}, 32'h0001);
    read_word("R8 first word kept", 32'hAAAA_0001);
    repeat (3) @(negedge clk);
    check("R8 pending word latched", {31'h0, drdy_n}, 32'h0);
    read_word("R8 newest pending word", 32'hCCCC_0003);
  endtask

  task automatic t_loop;
    logic [31:0] w;
    w = 32'h9C3E_6A15;
    line_a = 1'b1; line_b = 1'b1;
    loop_en = 1'b1; use_loop = 1'b1;
    rails(1'b0, 1'b0, 15);
    send(w, 32, 15, -1, 0);
    read_word("R11 inverted loopback", ~w);
    loop_en = 1'b0; use_loop = 1'b0;
    line_a = 1'b0; line_b = 1'b0;
    rails(1'b0, 1'b0, 15);
  endtask

  task automatic t_slow;
    logic [31:0] w;
    w = 32'h6B2D_8F41;
    rate_slow = 1'b1; spc = 8;
    rails(1'b0, 1'b0, 15 * spc);
    send(w, 32, 15, -1, 0);
    read_word("R1 slow rate word", w);
    rate_slow = 1'b0; spc = 1;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    t_reset();
    t_basic();
    t_len25();
    t_sd();
    t_break();
    t_no_trail();
    t_bad();
    t_glitch();
    t_hold();
    t_loop();
    t_slow();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end
endmodule